// File: doc/BRIEF.md
# Hierarchical DMA Channel Transfer Sequencer

This block is the address and count engine of one DMA channel. A transfer is organised in three nested levels: a transaction is divided into blocks, and each block is divided into fragments. Software loads a configuration into the engine. The configuration holds the following items:

- a control word, which carries the data widths, the request mode, the fixed-address controls and the fragment length;
- the block length and the transaction length;
- a step word, which holds a separate step for the source side and for the destination side;
- 36-bit source and destination base addresses.

Each start request then moves the amount of data that the request mode selects: one fragment, one block or the rest of the transaction. The engine presents one beat at a time on a request/acknowledge memory port. Each beat carries a read address, a write address and a byte count.

The engine reports boundaries by pulsing a fragment, block or transaction done output. It pulses these in the cycle after the beat that closes the boundary. After each serviced request the engine goes back to waiting for the next start. When the transaction length has been covered, the engine drops `busy`. A configuration that cannot be run is flagged on `cfg_err` and never starts.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `cfg_err` and all three done outputs are low.
- R2: A `cfg_load` with a valid configuration sets `busy`, clears `cfg_err` and restarts all counts and addresses from the loaded bases. A `cfg_load` while beats are being issued is ignored.
- R3: A load sets `cfg_err` and leaves `busy` low in any of these cases: a width code of 3, request mode 3, any length of zero, or any length that is not a multiple of the beat size. While `cfg_err` is set, start requests produce no beats.
- R4: The request mode sits in control bits [25:24]. Mode 0 runs to the next fragment end, mode 1 to the next block end and mode 2 to the transaction end.
- R5: The source width sits in control bits [31:30] and the destination width in bits [29:28], with 0 = byte, 1 = halfword and 2 = word. The beat size on `mem_bytes` is the wider of the two.
- R6: After each accepted beat, each side's address advances by its own step. The destination step is in step bits [31:16] and the source step in bits [15:0]. A zero step holds that side's address, and addresses are 36 bits wide.
- R7: When control bit 20 is set, the step of one side is forced to zero. Control bit 21 chooses that side: 0 means source and 1 means destination.
- R8: The fragment length sits in control bits [16:0]. Block length and transaction length are separate inputs. The done outputs pulse for one cycle after the boundary beat. The end of a higher level also ends every level below it, so coinciding pulses rise together.
- R9: `busy` falls together with `trsc_done`. A start request while `busy` is low produces no beats.
- R10: `mem_req` is raised only while `busy` is high. While `mem_ack` is low, `mem_req` and both addresses hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load configuration pulse |
| cfg_ctl | input | 32 | Control word: widths, mode, fixed-address bits, fragment length |
| cfg_blk_len | input | BLK_W | Block length in bytes |
| cfg_trsc_len | input | TRSC_W | Transaction length in bytes |
| cfg_step | input | 2*STEP_W | Destination step (upper half), source step (lower half) |
| cfg_src_addr | input | AW+HW | Source base address |
| cfg_dst_addr | input | AW+HW | Destination base address |
| start_req | input | 1 | Start one request's worth of beats |
| mem_req | output | 1 | Beat request |
| mem_rd_addr | output | AW+HW | Beat read address |
| mem_wr_addr | output | AW+HW | Beat write address |
| mem_bytes | output | 3 | Bytes per beat |
| mem_ack | input | 1 | Beat accepted |
| frag_done | output | 1 | Fragment boundary pulse |
| blk_done | output | 1 | Block boundary pulse |
| trsc_done | output | 1 | Transaction boundary pulse |
| busy | output | 1 | Transaction loaded and not yet finished |
| cfg_err | output | 1 | Last load was rejected |

## Verification
The hardest case to reach is a new load arriving while a run is stalled in the middle of a fragment. The bench forces it by holding the acknowledge low for several cycles after a start and pulsing `cfg_load` with different bases during that window. It then shows the load was discarded: the stalled run finishes on the old addresses, and the next request continues from where that run left off. The three-level coincidence is reached with uneven lengths, a 3-byte fragment inside a 5-byte block inside a 12-byte transaction. With these lengths, short trailing fragments and blocks are forced to close on the boundaries of the level above.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      MODE_FRAG  = 2'd0,
      MODE_BLOCK = 2'd1,
      MODE_TRANS = 2'd2,
      MODE_LIST  = 2'd3
   } req_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } seq_state_e;

   localparam int CTL_W        = 32;
   localparam int CTL_SRC_W_LO = 30;
   localparam int CTL_DST_W_LO = 28;
   localparam int CTL_MODE_LO  = 24;
   localparam int CTL_FIX_SEL  = 21;
   localparam int CTL_FIX_EN   = 20;
   localparam int CTL_RSVD_TOP = 19;

   localparam logic [1:0] WCODE_BAD = 2'd3;

   function automatic logic [1:0] align_mask(input logic [1:0] lg2);
      case (lg2)
         2'd1:    return 2'b01;
         2'd2:    return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/dma_seq_cfg_chk.sv
module dma_seq_cfg_chk
   import dma_seq_pkg::*;
#(
   parameter int FRAG_W = 17,
   parameter int BLK_W  = 17,
   parameter int TRSC_W = 28,
   parameter int STEP_W = 16,
   parameter int LEN_W  = 28,
   parameter int NLVL   = 3
) (
   input  logic [CTL_W-1:0]             ctl,
   input  logic [BLK_W-1:0]             blk_len,
   input  logic [TRSC_W-1:0]            trsc_len,
   input  logic [2*STEP_W-1:0]          step,
   output logic                         err,
   output req_mode_e                    mode,
   output logic [2:0]                   beat,
   output logic [NLVL-1:0][LEN_W-1:0]   lens,
   output logic [STEP_W-1:0]            src_step,
   output logic [STEP_W-1:0]            dst_step
);

   logic [1:0] sw_code, dw_code, lg2, amask;
   logic       width_bad, len_zero, len_misalign, fix_en, fix_sel;
   logic       unused_ctl_bits;

   assign sw_code = ctl[CTL_SRC_W_LO +: 2];
   assign dw_code = ctl[CTL_DST_W_LO +: 2];
   assign mode    = req_mode_e'(ctl[CTL_MODE_LO +: 2]);
   assign fix_en  = ctl[CTL_FIX_EN];
   assign fix_sel = ctl[CTL_FIX_SEL];

   assign unused_ctl_bits = ^{ctl[27:26], ctl[23:22], ctl[CTL_RSVD_TOP:FRAG_W]};

   assign width_bad = (sw_code == WCODE_BAD) || (dw_code == WCODE_BAD);
   assign lg2       = (sw_code > dw_code) ? sw_code : dw_code;
   assign beat      = width_bad ? 3'd0 : 3'(3'd1 << lg2);
   assign amask     = align_mask(lg2);

   assign lens[0] = LEN_W'(ctl[FRAG_W-1:0]);
   assign lens[1] = LEN_W'(blk_len);
   assign lens[2] = LEN_W'(trsc_len);

   always_comb begin
      len_zero     = 1'b0;
      len_misalign = 1'b0;
      for (int i = 0; i < NLVL; i++) begin
         if (lens[i] == '0)
            len_zero = 1'b1;
         if ((lens[i][1:0] & amask) != 2'b00)
            len_misalign = 1'b1;
      end
   end

   assign err = width_bad || (mode == MODE_LIST) || len_zero || len_misalign;

   assign src_step = (fix_en && !fix_sel) ? '0 : step[STEP_W-1:0];
   assign dst_step = (fix_en &&  fix_sel) ? '0 : step[2*STEP_W-1:STEP_W];

endmodule

// File: rtl/dma_seq_lvl_cnt.sv
module dma_seq_lvl_cnt #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [2:0]   beat,
   input  logic [W-1:0] len,
   input  logic         upper_end,
   output logic         end_o
);

   logic [W-1:0] cnt_q;
   logic [W:0]   nxt;
   logic         last;

   assign nxt   = {1'b0, cnt_q} + {{(W-2){1'b0}}, beat};
   assign last  = (nxt >= {1'b0, len});
   assign end_o = last || upper_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (adv)
         cnt_q <= end_o ? '0 : nxt[W-1:0];
   end

endmodule

// File: rtl/dma_seq_addr_gen.sv
module dma_seq_addr_gen #(
   parameter int AW = 36,
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic [SW-1:0] step,
   output logic [AW-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= base;
      else if (adv)
         addr <= addr + {{(AW-SW){1'b0}}, step};
   end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int AW     = 32,
   parameter int HW     = 4,
   parameter int FRAG_W = 17,
   parameter int BLK_W  = 17,
   parameter int TRSC_W = 28,
   parameter int STEP_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_load,
   input  logic [31:0]          cfg_ctl,
   input  logic [BLK_W-1:0]     cfg_blk_len,
   input  logic [TRSC_W-1:0]    cfg_trsc_len,
   input  logic [2*STEP_W-1:0]  cfg_step,
   input  logic [AW+HW-1:0]     cfg_src_addr,
   input  logic [AW+HW-1:0]     cfg_dst_addr,
   input  logic                 start_req,
   output logic                 mem_req,
   output logic [AW+HW-1:0]     mem_rd_addr,
   output logic [AW+HW-1:0]     mem_wr_addr,
   output logic [2:0]           mem_bytes,
   input  logic                 mem_ack,
   output logic                 frag_done,
   output logic                 blk_done,
   output logic                 trsc_done,
   output logic                 busy,
   output logic                 cfg_err
);

   localparam int FULL_AW = AW + HW;
   localparam int NLVL    = 3;
   localparam int NSIDE   = 2;
   localparam int LEN_W0  = (FRAG_W > BLK_W) ? FRAG_W : BLK_W;
   localparam int LEN_W   = (TRSC_W > LEN_W0) ? TRSC_W : LEN_W0;

   if (FRAG_W > CTL_RSVD_TOP) begin : g_bad_frag_w
      $error("FRAG_W must fit below control bit 19");
   end
   if (2 * STEP_W > CTL_W) begin : g_bad_step_w
      $error("two steps must fit in one 32-bit word");
   end
   if (STEP_W > FULL_AW || LEN_W < 3) begin : g_bad_geom
      $error("step or length width out of range");
   end

   logic                        chk_err;
   req_mode_e                   chk_mode;
   logic [2:0]                  chk_beat;
   logic [NLVL-1:0][LEN_W-1:0]  chk_len;
   logic [STEP_W-1:0]           chk_src_step, chk_dst_step;

   dma_seq_cfg_chk #(
      .FRAG_W (FRAG_W),
      .BLK_W  (BLK_W),
      .TRSC_W (TRSC_W),
      .STEP_W (STEP_W),
      .LEN_W  (LEN_W),
      .NLVL   (NLVL)
   ) u_cfg_chk (
      .ctl      (cfg_ctl),
      .blk_len  (cfg_blk_len),
      .trsc_len (cfg_trsc_len),
      .step     (cfg_step),
      .err      (chk_err),
      .mode     (chk_mode),
      .beat     (chk_beat),
      .lens     (chk_len),
      .src_step (chk_src_step),
      .dst_step (chk_dst_step)
   );

   seq_state_e                  state_q;
   req_mode_e                   mode_q;
   logic [2:0]                  beat_q;
   logic [NLVL-1:0][LEN_W-1:0]  len_q;
   logic [NSIDE-1:0][STEP_W-1:0] step_q;
   logic                        err_q;
   logic [NLVL-1:0]             done_q;
   logic [NLVL-1:0]             lvl_end;
   logic                        load_acc, beat_fire, req_end;

   assign load_acc  = cfg_load && (state_q != ST_RUN);
   assign beat_fire = (state_q == ST_RUN) && mem_ack;

   for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      logic up_end;
      if (g == NLVL - 1) begin : g_top
         assign up_end = 1'b0;
      end else begin : g_inner
         assign up_end = lvl_end[g+1];
      end
      dma_seq_lvl_cnt #(.W(LEN_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (load_acc),
         .adv       (beat_fire),
         .beat      (beat_q),
         .len       (len_q[g]),
         .upper_end (up_end),
         .end_o     (lvl_end[g])
      );
   end

   logic [NSIDE-1:0][FULL_AW-1:0] side_base, side_addr;
   assign side_base[0] = cfg_src_addr;
   assign side_base[1] = cfg_dst_addr;

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      dma_seq_addr_gen #(.AW(FULL_AW), .SW(STEP_W)) u_addr (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_acc),
         .base  (side_base[s]),
         .adv   (beat_fire),
         .step  (step_q[s]),
         .addr  (side_addr[s])
      );
   end

   always_comb begin
      case (mode_q)
         MODE_FRAG:  req_end = lvl_end[0];
         MODE_BLOCK: req_end = lvl_end[1];
         default:    req_end = lvl_end[2];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_FRAG;
         beat_q  <= '0;
         len_q   <= '0;
         step_q  <= '0;
         err_q   <= 1'b0;
         done_q  <= '0;
      end else begin
         done_q <= beat_fire ? lvl_end : '0;
         if (load_acc) begin
            err_q     <= chk_err;
            mode_q    <= chk_mode;
            beat_q    <= chk_beat;
            len_q     <= chk_len;
            step_q[0] <= chk_src_step;
            step_q[1] <= chk_dst_step;
            state_q   <= chk_err ? ST_IDLE : ST_ARMED;
         end else begin
            case (state_q)
               ST_ARMED: if (start_req) state_q <= ST_RUN;
               ST_RUN:   if (beat_fire && req_end)
                            state_q <= lvl_end[NLVL-1] ? ST_IDLE : ST_ARMED;
               default:  ;
            endcase
         end
      end
   end

   assign mem_req     = (state_q == ST_RUN);
   assign mem_rd_addr = side_addr[0];
   assign mem_wr_addr = side_addr[1];
   assign mem_bytes   = beat_q;
   assign frag_done   = done_q[0];
   assign blk_done    = done_q[1];
   assign trsc_done   = done_q[2];
   assign busy        = (state_q != ST_IDLE);
   assign cfg_err     = err_q;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
   parameter int FULL_AW = 36
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mem_req,
   input logic               mem_ack,
   input logic [FULL_AW-1:0] mem_rd_addr,
   input logic [FULL_AW-1:0] mem_wr_addr,
   input logic               frag_done,
   input logic               blk_done,
   input logic               trsc_done,
   input logic               busy,
   input logic               cfg_err
);

   AST_BLK_HAS_FRAG:   assert property (@(posedge clk) disable iff (!rst_n) blk_done |-> frag_done);   // R8
   AST_TRSC_HAS_BLK:   assert property (@(posedge clk) disable iff (!rst_n) trsc_done |-> blk_done);   // R8
   AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
                          frag_done |-> $past(mem_req && mem_ack));                                    // R8
   AST_TRSC_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) trsc_done |-> !busy);    // R9
   AST_REQ_WHEN_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);        // R10
   AST_ERR_IDLE:       assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> !busy);       // R3
   AST_HOLD_ON_STALL:  assert property (@(posedge clk) disable iff (!rst_n)
                          (mem_req && !mem_ack) |=> (mem_req && $stable(mem_rd_addr)
                                                     && $stable(mem_wr_addr)));                        // R10

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.FULL_AW(AW + HW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_ack     (mem_ack),
   .mem_rd_addr (mem_rd_addr),
   .mem_wr_addr (mem_wr_addr),
   .frag_done   (frag_done),
   .blk_done    (blk_done),
   .trsc_done   (trsc_done),
   .busy        (busy),
   .cfg_err     (cfg_err)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic [31:0]   cfg_ctl = '0;
   logic [16:0]   cfg_blk_len = '0;
   logic [27:0]   cfg_trsc_len = '0;
   logic [31:0]   cfg_step = '0;
   logic [AW-1:0] cfg_src_addr = '0;
   logic [AW-1:0] cfg_dst_addr = '0;
   logic          start_req = 1'b0;
   logic          ack_en = 1'b1;
   logic          mem_req, mem_ack, frag_done, blk_done, trsc_done, busy, cfg_err;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic [2:0]    mem_bytes;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   int            n_beats, n_frag, n_blk, n_trsc;
   logic [AW-1:0] first_rd, first_wr, last_rd, last_wr;
   logic [2:0]    last_bytes;

   assign mem_ack = ack_en;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_seq u_dma_chan_seq (
      .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_ctl (cfg_ctl),
      .cfg_blk_len (cfg_blk_len), .cfg_trsc_len (cfg_trsc_len), .cfg_step (cfg_step),
      .cfg_src_addr (cfg_src_addr), .cfg_dst_addr (cfg_dst_addr), .start_req (start_req),
      .mem_req (mem_req), .mem_rd_addr (mem_rd_addr), .mem_wr_addr (mem_wr_addr),
      .mem_bytes (mem_bytes), .mem_ack (mem_ack), .frag_done (frag_done),
      .blk_done (blk_done), .trsc_done (trsc_done), .busy (busy), .cfg_err (cfg_err)
   );

   function automatic logic [31:0] mk_ctl(input int sw, input int dw, input int mode,
                                          input int fsel, input int fen, input int frag);
      logic [31:0] w;
      w = '0;
      w[31:30] = 2'(sw);
      w[29:28] = 2'(dw);
      w[25:24] = 2'(mode);
      w[21]    = 1'(fsel);
      w[20]    = 1'(fen);
      w[16:0]  = 17'(frag);
      return w;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic load_cfg(input logic [31:0] ctl, input int blk, input int trsc,
                           input logic [31:0] step, input logic [AW-1:0] src,
                           input logic [AW-1:0] dst);
      cfg_ctl = ctl; cfg_blk_len = 17'(blk); cfg_trsc_len = 28'(trsc);
      cfg_step = step; cfg_src_addr = src; cfg_dst_addr = dst;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic run_req(input int stall, input bit poke);
      n_beats = 0; n_frag = 0; n_blk = 0; n_trsc = 0;
      first_rd = '0; first_wr = '0; last_rd = '0; last_wr = '0; last_bytes = '0;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      for (int c = 0; c < 60; c++) begin
         ack_en   = (c >= stall);
         cfg_load = poke && (c == 1);
         if (mem_req && ack_en) begin
            if (n_beats == 0) begin first_rd = mem_rd_addr; first_wr = mem_wr_addr; end
            last_rd = mem_rd_addr; last_wr = mem_wr_addr; last_bytes = mem_bytes;
            n_beats++;
         end
         if (frag_done) n_frag++;
         if (blk_done)  n_blk++;
         if (trsc_done) n_trsc++;
         @(negedge clk);
      end
      ack_en = 1'b1;
      cfg_load = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 busy",      64'(busy), 0);
      check("R1 mem_req",   64'(mem_req), 0);
      check("R1 cfg_err",   64'(cfg_err), 0);
      check("R1 done",      64'({frag_done, blk_done, trsc_done}), 0);
   endtask

   // R4 fragment mode, R6 stepping with 36-bit bases, R9 completion
   task automatic t_frag_mode();
      logic [AW-1:0] a, b;
      a = 36'h1_0000_0100; b = 36'h2_0000_0200;
      load_cfg(mk_ctl(2, 2, 0, 0, 0, 8), 16, 32, {16'd4, 16'd4}, a, b);
      check("R2 busy after load", 64'(busy), 1);
      check("R2 err after load",  64'(cfg_err), 0);
      for (int r = 0; r < 4; r++) begin
         run_req(0, 0);
         check("R4 frag beats", 64'(n_beats), 2);
         check("R8 frag pulses", 64'(n_frag), 1);
         check("R8 blk pulses",  64'(n_blk), (r % 2 == 1) ? 1 : 0);
         check("R8 trsc pulses", 64'(n_trsc), (r == 3) ? 1 : 0);
         check("R6 first rd", 64'(first_rd), 64'(a + 36'(8 * r)));
         check("R6 last wr",  64'(last_wr),  64'(b + 36'(8 * r + 4)));
         check("R5 word bytes", 64'(last_bytes), 4);
         check("R9 busy", 64'(busy), (r == 3) ? 0 : 1);
      end
      run_req(0, 0);
      check("R9 start while idle", 64'(n_beats), 0);
   endtask

   // R4 block mode, R5 halfword, R6 zero step holds an address
   task automatic t_block_mode();
      logic [AW-1:0] a, b;
      a = 36'h0_0000_1000; b = 36'hF_FFFF_FFF0;
      load_cfg(mk_ctl(1, 1, 1, 0, 0, 4), 8, 16, {16'd0, 16'd2}, a, b);
      for (int r = 0; r < 2; r++) begin
         run_req(0, 0);
         check("R4 block beats", 64'(n_beats), 4);
         check("R8 block frag pulses", 64'(n_frag), 2);
         check("R8 block blk pulses",  64'(n_blk), 1);
         check("R8 block trsc pulses", 64'(n_trsc), r);
         check("R6 block first rd", 64'(first_rd), 64'(a + 36'(8 * r)));
         check("R6 block last rd",  64'(last_rd),  64'(a + 36'(8 * r + 6)));
         check("R6 zero step wr",   64'(last_wr),  64'(b));
         check("R5 halfword bytes", 64'(last_bytes), 2);
      end
      check("R9 block busy end", 64'(busy), 0);
   endtask

   // R4 transaction mode, R7 fixed destination, R8 nested coincidence
   task automatic t_trans_mode();
      logic [AW-1:0] a, b;
      a = 36'h3_0000_0000; b = 36'h0_0000_0040;
      load_cfg(mk_ctl(0, 0, 2, 1, 1, 3), 5, 12, {16'd1, 16'd1}, a, b);
      run_req(0, 0);
      check("R4 trans beats", 64'(n_beats), 12);
      check("R8 trans frag pulses", 64'(n_frag), 5);
      check("R8 trans blk pulses",  64'(n_blk), 3);
      check("R8 trans trsc pulses", 64'(n_trsc), 1);
      check("R7 fixed dst wr", 64'(last_wr), 64'(b));
      check("R6 trans last rd", 64'(last_rd), 64'(a + 36'd11));
      check("R5 byte bytes", 64'(last_bytes), 1);
      check("R9 trans busy end", 64'(busy), 0);
   endtask

   // R3 rejected configurations, R5 mixed widths
   task automatic t_errors();
      load_cfg(mk_ctl(3, 0, 0, 0, 0, 4), 4, 4, 32'h0001_0001, '0, '0);
      check("R3 width code 3 err", 64'(cfg_err), 1);
      check("R3 width code 3 busy", 64'(busy), 0);
      load_cfg(mk_ctl(2, 2, 0, 0, 0, 6), 8, 8, 32'h0004_0004, '0, '0);
      check("R3 misaligned err", 64'(cfg_err), 1);
      load_cfg(mk_ctl(0, 0, 3, 0, 0, 4), 4, 4, 32'h0001_0001, '0, '0);
      check("R3 list mode err", 64'(cfg_err), 1);
      load_cfg(mk_ctl(0, 0, 0, 0, 0, 4), 4, 0, 32'h0001_0001, '0, '0);
      check("R3 zero length err", 64'(cfg_err), 1);
      run_req(0, 0);
      check("R3 start after err", 64'(n_beats), 0);
      load_cfg(mk_ctl(0, 2, 2, 0, 1, 4), 4, 8, 32'h0004_0004, 36'h100, 36'h200);
      check("R2 err cleared", 64'(cfg_err), 0);
      run_req(0, 0);
      check("R5 mixed width bytes", 64'(last_bytes), 4);
      check("R5 mixed width beats", 64'(n_beats), 2);
      check("R7 fixed src rd", 64'(last_rd), 64'h100);
      check("R6 mixed wr", 64'(last_wr), 64'h204);
   endtask

   // R2 load during a stalled run is ignored, R10 stall handling
   task automatic t_stall_load();
      logic [AW-1:0] a, b;
      a = 36'h0_0000_8000; b = 36'h0_0000_9000;
      load_cfg(mk_ctl(2, 2, 0, 0, 0, 8), 8, 16, {16'd4, 16'd4}, a, b);
      cfg_src_addr = 36'h0_0ABC_0000;
      cfg_dst_addr = 36'h0_0DEF_0000;
      run_req(4, 1);
      check("R10 stalled beats", 64'(n_beats), 2);
      check("R2 load ignored rd", 64'(first_rd), 64'(a));
      check("R10 stalled last wr", 64'(last_wr), 64'(b + 36'd4));
      check("R2 still busy", 64'(busy), 1);
      run_req(0, 0);
      check("R2 continues rd", 64'(first_rd), 64'(a + 36'd8));
      check("R9 stall busy end", 64'(busy), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frag_mode();
      t_block_mode();
      t_trans_mode();
      t_errors();
      t_stall_load();
      summary();
   end

endmodule